// File: doc/BRIEF.md
# Shared-Bus Debug Master with Acknowledge Watchdog

This block lets a debug front end run single read and write cycles on a Wishbone classic bus that already has a primary master. For each operation it first raises a bus request toward the primary master. It starts the cycle only after the grant comes back. It then drives address, write enable and write data, and holds the cycle open until the slave acknowledges. Read data is captured on a separate input bus. The result goes back to the front end as a status code together with a one-clock done pulse.

A watchdog counts the clocks of every cycle and closes the cycle with a timeout status if no acknowledge has come by the limit. A slave error input closes the cycle with a bus-error status. The front end can chain several operations under one bus ownership by marking only the final one as last. The block also serves as the sole bus master when grant is tied high, and it gives one-clock cycles when acknowledge is tied high.

Top module: `dbg_bus_master`

## Requirements
- R1: While an operation is pending, `busReq` is high. `wbCyc` never rises unless `busGnt` was high in the clock before. With the grant held back for d clocks after a fresh request, the cycle starts d+1 clocks after the operation is accepted.
- R2: With `busGnt` and `wbAck` tied high, an accepted operation raises `wbCyc` for exactly one clock, starting one clock after acceptance. `opDone` follows in the next clock.
- R3: `wbCyc` and `wbStb` rise and fall together. During a cycle, `wbWe`, `wbAdr` and `wbDatO` stay equal to the accepted operation's values. `wbCyc` falls in the clock right after the terminating acknowledge, error or timeout.
- R4: A cycle whose acknowledge comes on its n-th clock, with n not above `WD_LIMIT`, lasts exactly n clocks and ends with status 2'b00 (OK).
- R5: A cycle with no acknowledge and no error ends after exactly `WD_LIMIT` clocks with status 2'b01 (timeout). The watchdog restarts from zero for every cycle.
- R6: An acknowledge arriving on the same clock that the watchdog expires wins, and the status is 2'b00.
- R7: An error on the n-th clock of a cycle (n not above `WD_LIMIT`) ends the cycle after n clocks with status 2'b10 (bus error). An error and an acknowledge on the same clock give 2'b00.
- R8: A read that ends with OK presents the slave's data on `opRdata` from the `opDone` clock onward. A write's data appears on `wbDatO`.
- R9: After an operation with `opLast` low, `busReq` stays high while the block waits for the next operation. `busReq` drops in the same clock that `opDone` reports an operation with `opLast` high.
- R10: `opDone` is a single-clock pulse and `opStatus` is valid in that clock. `opReady` is high only while no operation is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Front end offers an operation (taken when opReady is high) |
| opWrite | input | 1 | 1 = write, 0 = read |
| opAddr | input | ADDR_W | Operation address |
| opWdata | input | DATA_W | Operation write data |
| opLast | input | 1 | Release the bus after this operation |
| opReady | output | 1 | Block can take an operation |
| opDone | output | 1 | One-clock completion pulse |
| opStatus | output | 2 | 00 OK, 01 timeout, 10 bus error |
| opRdata | output | DATA_W | Data of the last successful read |
| busReq | output | 1 | Bus ownership request to the primary master |
| busGnt | input | 1 | Bus ownership grant |
| wbCyc | output | 1 | Bus cycle |
| wbStb | output | 1 | Bus strobe |
| wbWe | output | 1 | Bus write enable |
| wbAdr | output | ADDR_W | Bus address |
| wbDatO | output | DATA_W | Bus write data |
| wbDatI | input | DATA_W | Bus read data |
| wbAck | input | 1 | Slave acknowledge |
| wbErr | input | 1 | Slave error |

## Verification
The bench builds the block with 16-bit address and data and a watchdog limit of 8 clocks. This short limit lets the slave's programmable latency sweep across the whole range: below the limit, on the exact expiry clock where acknowledge must win, and past it into timeout. Many timeouts fit into a short run. The grant delay is set per operation, with a tied-high grant and a tied-high acknowledge for the sole-master case. Chained operations with and without the last flag exercise how long the request is held.

// File: rtl/dbg_bus_pkg.sv
package dbg_bus_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'b00,
    ST_TIMEOUT = 2'b01,
    ST_BUSERR  = 2'b10
  } busStatus_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WAITG,
    S_CYC,
    S_HOLD
  } ctrlState_e;

  typedef struct packed {
    logic loadOp;
    logic clearWd;
    logic runWd;
    logic captureRd;
  } dpStrobe_t;

endpackage

// File: rtl/dbg_bus_dpath.sv
module dbg_bus_dpath
  import dbg_bus_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WD_LIMIT = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              opWrite,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opWdata,
  input  logic              opLast,
  input  logic [DATA_W-1:0] wbDatI,
  output logic [ADDR_W-1:0] wbAdr,
  output logic [DATA_W-1:0] wbDatO,
  output logic              wbWe,
  output logic              isLast,
  output logic              wdExpired,
  output logic [DATA_W-1:0] opRdata
);

  localparam int WD_W = $clog2(WD_LIMIT + 1);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(WD_LIMIT - 1);
  localparam logic [WD_W-1:0] WD_TOP  = WD_W'(WD_LIMIT);

  logic [WD_W-1:0] wdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbAdr  <= '0;
      wbDatO <= '0;
      wbWe   <= 1'b0;
      isLast <= 1'b0;
    end else if (strobe.loadOp) begin
      wbAdr  <= opAddr;
      wbDatO <= opWdata;
      wbWe   <= opWrite;
      isLast <= opLast;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdCnt <= '0;
    end else if (strobe.clearWd) begin
      wdCnt <= '0;
    end else if (strobe.runWd && !wdExpired) begin
      wdCnt <= wdCnt + 1'b1;
    end
  end

  assign wdExpired = (wdCnt == WD_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opRdata <= '0;
    end else if (strobe.captureRd && !wbWe) begin
      opRdata <= wbDatI;
    end
  end

  // watchdog never runs past its limit inside a cycle
  assert_wd_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.runWd |-> (wdCnt < WD_TOP));

  // bus-side request fields hold while a cycle runs
  assert_fields_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.runWd && $past(strobe.runWd)) |->
      ($stable(wbWe) && $stable(wbAdr) && $stable(wbDatO)));

endmodule

// File: rtl/dbg_bus_ctrl.sv
module dbg_bus_ctrl
  import dbg_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic       busGnt,
  input  logic       wbAck,
  input  logic       wbErr,
  input  logic       isLast,
  input  logic       wdExpired,
  output logic       opReady,
  output logic       busReq,
  output logic       wbCyc,
  output logic       wbStb,
  output logic       opDone,
  output logic [1:0] opStatus,
  output dpStrobe_t  strobe
);

  ctrlState_e state, nextState;
  logic       cycEnd;
  busStatus_e endStatus;

  always_comb begin
    nextState = state;
    strobe    = '0;
    cycEnd    = 1'b0;
    endStatus = ST_OK;
    case (state)
      S_IDLE, S_HOLD: begin
        if (opValid) begin
          strobe.loadOp = 1'b1;
          nextState     = S_WAITG;
        end
      end
      S_WAITG: begin
        if (busGnt) begin
          strobe.clearWd = 1'b1;
          nextState      = S_CYC;
        end
      end
      S_CYC: begin
        strobe.runWd     = 1'b1;
        strobe.captureRd = wbAck;
        cycEnd           = wbAck || wbErr || wdExpired;
        if (wbAck)       endStatus = ST_OK;
        else if (wbErr)  endStatus = ST_BUSERR;
        else             endStatus = ST_TIMEOUT;
        if (cycEnd) nextState = isLast ? S_IDLE : S_HOLD;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      opDone   <= 1'b0;
      opStatus <= ST_OK;
    end else begin
      state  <= nextState;
      opDone <= cycEnd;
      if (cycEnd) opStatus <= endStatus;
    end
  end

  assign wbCyc   = (state == S_CYC);
  assign wbStb   = (state == S_CYC);
  assign busReq  = (state != S_IDLE);
  assign opReady = (state == S_IDLE) || (state == S_HOLD);

  assert_no_cyc_without_gnt_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAITG && !busGnt) |=> !wbCyc);

  assert_cyc_falls_with_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wbCyc) |-> opDone);

  assert_ack_ends_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && wbAck) |=> (!wbCyc && opDone));

  assert_ack_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && wbAck) |=> (opStatus == ST_OK));

  assert_err_status_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wbCyc && wbErr && !wbAck) |=> (opDone && opStatus == ST_BUSERR));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> !opDone);

endmodule

// File: rtl/dbg_bus_master.sv
module dbg_bus_master
  import dbg_bus_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WD_LIMIT = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic              opWrite,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opWdata,
  input  logic              opLast,
  output logic              opReady,
  output logic              opDone,
  output logic [1:0]        opStatus,
  output logic [DATA_W-1:0] opRdata,
  output logic              busReq,
  input  logic              busGnt,
  output logic              wbCyc,
  output logic              wbStb,
  output logic              wbWe,
  output logic [ADDR_W-1:0] wbAdr,
  output logic [DATA_W-1:0] wbDatO,
  input  logic [DATA_W-1:0] wbDatI,
  input  logic              wbAck,
  input  logic              wbErr
);

  dpStrobe_t strobe;
  logic      isLast;
  logic      wdExpired;

  dbg_bus_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .busGnt    (busGnt),
    .wbAck     (wbAck),
    .wbErr     (wbErr),
    .isLast    (isLast),
    .wdExpired (wdExpired),
    .opReady   (opReady),
    .busReq    (busReq),
    .wbCyc     (wbCyc),
    .wbStb     (wbStb),
    .opDone    (opDone),
    .opStatus  (opStatus),
    .strobe    (strobe)
  );

  dbg_bus_dpath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .WD_LIMIT (WD_LIMIT)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opWrite   (opWrite),
    .opAddr    (opAddr),
    .opWdata   (opWdata),
    .opLast    (opLast),
    .wbDatI    (wbDatI),
    .wbAdr     (wbAdr),
    .wbDatO    (wbDatO),
    .wbWe      (wbWe),
    .isLast    (isLast),
    .wdExpired (wdExpired),
    .opRdata   (opRdata)
  );

endmodule

// File: tb/dbg_bus_master_tb.sv
module dbg_bus_master_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int WD = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0, opWrite = 1'b0, opLast = 1'b0;
  logic [AW-1:0] opAddr = '0;
  logic [DW-1:0] opWdata = '0;
  logic opReady, opDone, busReq, wbCyc, wbStb, wbWe;
  logic [1:0] opStatus;
  logic [DW-1:0] opRdata, wbDatO, wbDatI;
  logic [AW-1:0] wbAdr;
  logic busGnt, wbAck, wbErr;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // slave model
  logic [DW-1:0] mem [16];
  logic [DW-1:0] shadow [16];
  int slvLat = 0;
  bit slvErr = 0;
  bit slvAckHigh = 0;
  int slvCnt = 0;

  // grant model
  bit gntTie = 1;
  int gntDelay = 0;
  int reqCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_bus_master #(.ADDR_W(AW), .DATA_W(DW), .WD_LIMIT(WD)) dut_i (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opWrite(opWrite),
    .opAddr(opAddr), .opWdata(opWdata), .opLast(opLast), .opReady(opReady),
    .opDone(opDone), .opStatus(opStatus), .opRdata(opRdata), .busReq(busReq),
    .busGnt(busGnt), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe), .wbAdr(wbAdr),
    .wbDatO(wbDatO), .wbDatI(wbDatI), .wbAck(wbAck), .wbErr(wbErr)
  );

  always @(posedge clk) begin
    slvCnt <= wbCyc ? slvCnt + 1 : 0;
    reqCnt <= busReq ? reqCnt + 1 : 0;
    if (wbCyc && wbStb && wbWe && wbAck) mem[wbAdr[3:0]] <= wbDatO;
  end

  always @* begin
    wbAck  = slvAckHigh || (wbCyc && !slvErr && slvCnt == slvLat);
    wbErr  = wbCyc && slvErr && !slvAckHigh && slvCnt == slvLat;
    wbDatI = mem[wbAdr[3:0]];
    busGnt = gntTie || (busReq && reqCnt >= gntDelay);
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expStatus(int lat, bit err, bit ackHigh);
    if (ackHigh) return 0;
    if (lat < WD) return err ? 2 : 0;
    return 1;
  endfunction

  function automatic int expCycLen(int lat, bit ackHigh);
    if (ackHigh) return 1;
    if (lat < WD) return lat + 1;
    return WD;
  endfunction

  task automatic doOp(bit w, logic [AW-1:0] a, logic [DW-1:0] d, bit last,
                      int lat, bit err, bit ackHigh);
    int waitCnt = 0;
    int cycCnt = 0;
    int fieldBad = 0;
    int gntBad = 0;
    bit prevGnt = 0;
    bit prevCyc = 0;
    bit seenDone = 0;
    bit fromIdle;
    int expWait;
    int st;
    for (int k = 0; k < 50 && !opReady; k++) @(negedge clk);
    slvLat = lat; slvErr = err; slvAckHigh = ackHigh;
    fromIdle = !busReq;
    expWait = (!gntTie && fromIdle) ? gntDelay + 1 : 1;
    opValid = 1; opWrite = w; opAddr = a; opWdata = d; opLast = last;
    @(negedge clk);
    opValid = 0;
    for (int k = 0; k < 300; k++) begin
      if (k > 0) @(negedge clk);
      if (opDone) begin seenDone = 1; break; end
      if (wbCyc) begin
        cycCnt++;
        if (!prevCyc && !prevGnt) gntBad++;
        if (wbStb != 1'b1 || wbWe != w || wbAdr != a || (w && wbDatO != d)) fieldBad++;
      end else begin
        if (wbStb) fieldBad++;
        if (cycCnt == 0) waitCnt++;
        if (!busReq) gntBad++;
      end
      prevGnt = busGnt; prevCyc = wbCyc;
    end
    check(seenDone, "R10", "done seen", seenDone, 1);
    check(gntBad == 0, "R1", "cycle without grant or request", gntBad, 0);
    check(waitCnt == expWait, "R1", "clocks before cycle", waitCnt, expWait);
    check(fieldBad == 0, "R3", "bus fields during cycle", fieldBad, 0);
    check(!wbCyc, "R3", "cycle dropped at done", wbCyc, 0);
    check(cycCnt == expCycLen(lat, ackHigh),
          ackHigh ? "R2" : (lat >= WD ? "R5" : (err ? "R7" : "R4")),
          "cycle length", cycCnt, expCycLen(lat, ackHigh));
    st = expStatus(lat, err, ackHigh);
    check(int'(opStatus) == st, (lat == WD-1 && !err) ? "R6" : (st == 2 ? "R7" : "R5"),
          "status", opStatus, st);
    if (!w && st == 0)
      check(opRdata == shadow[a[3:0]], "R8", "read data", opRdata, shadow[a[3:0]]);
    if (w && st == 0) shadow[a[3:0]] = d;
    check(busReq == !last, "R9", "request after done", busReq, !last);
    @(negedge clk);
    check(!opDone, "R10", "done is one clock", opDone, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!opDone && !wbCyc && !busReq && opReady && opStatus == 2'b00,
          "R10", "reset state", {opDone, wbCyc, busReq}, 0);
    rstN = 1;
    @(negedge clk);

    // sole master, tied ack: fill every slave word
    gntTie = 1;
    for (int i = 0; i < 16; i++)
      doOp(1, AW'(i), DW'(16'h1111 * i + 7), 1, 0, 0, 1);
    for (int i = 0; i < 16; i++)
      doOp(0, AW'(i), '0, 1, 0, 0, 1);

    // shared bus with grant delay, chained operations
    gntTie = 0; gntDelay = 3;
    doOp(1, 16'h0003, 16'hbeef, 0, 2, 0, 0);
    doOp(0, 16'h0003, '0, 0, 0, 0, 0);
    repeat (5) begin
      @(negedge clk);
      check(busReq && !wbCyc, "R9", "request held between chained ops", busReq, 1);
    end
    doOp(1, 16'h0105, 16'h5a5a, 0, 5, 0, 0);
    doOp(0, 16'h0005, '0, 1, 1, 0, 0);
    check(!busReq, "R9", "request released", busReq, 0);

    // watchdog corners
    gntDelay = 0;
    doOp(0, 16'h0002, '0, 1, WD-1, 0, 0);   // R6 ack on expiry clock
    doOp(0, 16'h0002, '0, 0, WD, 0, 0);     // R5 timeout
    doOp(1, 16'h0002, 16'hdead, 0, 500, 0, 0); // R5 restart, no write
    doOp(0, 16'h0002, '0, 1, 0, 0, 0);
    doOp(1, 16'h0004, 16'h1234, 1, 0, 1, 0);  // R7 error, no write
    doOp(0, 16'h0004, '0, 1, 3, 0, 0);
    doOp(0, 16'h0006, '0, 1, WD-1, 1, 0);     // R7 error on last clock
    doOp(0, 16'h0006, '0, 1, WD + 2, 1, 0);   // error too late -> timeout

    // random mix
    for (int n = 0; n < 150; n++) begin
      int lat;
      gntTie = ($urandom % 4) == 0;
      gntDelay = $urandom % 4;
      lat = $urandom % (WD + 3);
      doOp($urandom % 2, AW'($urandom), DW'($urandom), ($urandom % 3) == 0,
           lat, ($urandom % 5) == 0, ($urandom % 8) == 0);
    end
    gntTie = 1;
    doOp(0, 16'h0000, '0, 1, 0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule